// File: doc/BRIEF.md
# Branch trace message generator

This block sits between a processor core and its system bus interface. Each cycle the core may report one retired taken branch, giving the branch target, the address of the branch instruction, the address of the instruction after it, and whether the branch completed normally. While tracing is switched on, each such report becomes a 64-bit trace message for the bus. The core may also pulse a rare-event request with a 3-bit event code. Each such request becomes a special bus transaction whose 8-bit sub-code is that event code, zero-extended.

Both kinds of request go through one small queue and leave through one request port with a valid/ready handshake. A trace message is followed by a 64-bit data phase that has its own valid/ready handshake. A special transaction has no data phase. The address field of both kinds is a don't-care, so it is not brought out. Target-ready and response generation belong to the central agent and are not part of this block. If an event finds the queue full, it is dropped and a sticky overflow flag is raised.

Top module: `trace_msg_gen`

## Requirements
- R1: A trace message is queued only in a cycle where `br_valid` and `trace_en` are both 1. A branch reported with `trace_en` at 0 produces no request.
- R2: Bits 63:32 of the trace data word equal `br_target`.
- R3: Bits 31:0 of the trace data word equal `br_next_addr` when `br_normal` is 1. They equal `br_insn_addr` when `br_normal` is 0.
- R4: While `dat_valid` is 1, `dat_be` is 8'hFF. It is 0 otherwise.
- R5: A trace request shows `req_kind_a`=1, `req_kind_b`=2'b00 and `req_subcode`=8'hFF.
- R6: A special request shows `req_kind_a`=0, `req_kind_b`=2'b01 and `req_subcode`={5'b0, `sp_code`}. The codes are: 0 no-op, 1 shutdown, 2 flush, 3 halt, 4 sync, 5 flush acknowledge, 6 stop-clock acknowledge, 7 interrupt-mode acknowledge. No sub-code in 8..254 is ever emitted.
- R7: When a special event and a traced branch arrive in the same cycle, the special request is delivered first and the trace request after it.
- R8: A pending request holds `req_valid` and its fields stable until `req_ready` is seen. `dat_valid` rises in the cycle after a trace request is accepted. The data word then holds until `dat_ready` is seen.
- R9: The queue holds `DEPTH` (default 4) entries. An event that finds no free slot is dropped and sets `overflow`, which stays 1 until reset. The entries already queued are delivered in their order.
- R10: Clearing `trace_en` does not discard trace messages that are already queued. They are still delivered.
- R11: Accepting a special request starts no data phase. `dat_valid` stays 0 in the following cycle.
- R12: After reset, `req_valid`, `dat_valid` and `overflow` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trace_en | input | 1 | Execution tracing enable |
| br_valid | input | 1 | One-cycle pulse: a taken branch retired |
| br_target | input | 32 | Linear address of the branch target |
| br_insn_addr | input | 32 | Address of the branch instruction's first byte |
| br_next_addr | input | 32 | Address of the instruction after the branch |
| br_normal | input | 1 | Branch completed normally |
| sp_valid | input | 1 | One-cycle pulse: special event request |
| sp_code | input | 3 | Special event code |
| req_valid | output | 1 | Request phase valid |
| req_ready | input | 1 | Bus accepts the request |
| req_kind_a | output | 1 | Request-type bit A (1 for trace) |
| req_kind_b | output | 2 | Request-type bits B (00 trace, 01 special) |
| req_subcode | output | 8 | Sub-code field (FF for trace, 00..07 for special) |
| dat_valid | output | 1 | Data phase valid |
| dat_ready | input | 1 | Bus takes the data word |
| dat_word | output | 64 | Trace data word |
| dat_be | output | 8 | Byte enables of the data phase |
| overflow | output | 1 | Sticky flag: an event was dropped |

## Verification
The embedded assertions check on every cycle that requests and data words hold while their handshakes wait. They also check that a data phase follows only an accepted trace request, that byte enables are full during data phases, that the request-type and sub-code fields are consistent with each kind, that queue occupancy stays bounded, and that the overflow flag is sticky. The directed scenarios are needed for the rest. These cover the choice of the low data word, ordering within one cycle, suppression while tracing is off, delivery of queued messages after tracing is disabled, and which events the overflow drops.

// File: rtl/trc_pkg.sv
package trc_pkg;
  localparam int ADDR_W = 32;
  localparam int DATA_W = 2 * ADDR_W;
  localparam int BE_W   = DATA_W / 8;

  typedef struct packed {
    logic              is_trace;
    logic [2:0]        code;
    logic [DATA_W-1:0] data;
  } trc_entry_t;

  // Trace data word: target on top, low half picked by completion status.
  function automatic logic [DATA_W-1:0] trc_pack_data(
      input logic [ADDR_W-1:0] tgt,
      input logic [ADDR_W-1:0] insn,
      input logic [ADDR_W-1:0] nxt,
      input logic              normal);
    return {tgt, (normal ? nxt : insn)};
  endfunction

  // Sub-code field: fixed all-ones for trace, zero-extended event code otherwise.
  function automatic logic [7:0] trc_sub_code(input logic is_trace, input logic [2:0] code);
    return is_trace ? 8'hFF : {5'b0, code};
  endfunction

  function automatic logic [1:0] trc_kind_b(input logic is_trace);
    return is_trace ? 2'b00 : 2'b01;
  endfunction
endpackage

// File: rtl/trc_encoder.sv
module trc_encoder
  import trc_pkg::*;
(
  input  logic              trace_en,
  input  logic              br_valid,
  input  logic [ADDR_W-1:0] br_target,
  input  logic [ADDR_W-1:0] br_insn_addr,
  input  logic [ADDR_W-1:0] br_next_addr,
  input  logic              br_normal,
  input  logic              sp_valid,
  input  logic [2:0]        sp_code,
  output logic              slot0_vld,
  output trc_entry_t        slot0,
  output logic              slot1_vld,
  output trc_entry_t        slot1
);
  logic       br_take;
  trc_entry_t br_ent;
  trc_entry_t sp_ent;

  assign br_take = br_valid && trace_en;

  always_comb begin
    br_ent          = '0;
    br_ent.is_trace = 1'b1;
    br_ent.data     = trc_pack_data(br_target, br_insn_addr, br_next_addr, br_normal);
    sp_ent          = '0;
    sp_ent.is_trace = 1'b0;
    sp_ent.code     = sp_code;
  end

  // Special event takes the first slot when both arrive together.
  assign slot0_vld = sp_valid || br_take;
  assign slot0     = sp_valid ? sp_ent : br_ent;
  assign slot1_vld = sp_valid && br_take;
  assign slot1     = br_ent;
endmodule

// File: rtl/trc_fifo.sv
module trc_fifo
  import trc_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in0_vld,
  input  trc_entry_t in0,
  input  logic       in1_vld,
  input  trc_entry_t in1,
  input  logic       pop,
  output trc_entry_t head,
  output logic       empty,
  output logic       drop
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  trc_entry_t      mem [DEPTH];
  logic [PW-1:0]   wr_ptr, rd_ptr;
  logic [CW-1:0]   count, free;
  logic            acc0, acc1, pop_eff;
  logic [CW-1:0]   n_push;

  assign free    = CW'(DEPTH) - count;
  assign acc0    = in0_vld && (free != '0);
  assign acc1    = in1_vld && (free > CW'(acc0));
  assign n_push  = CW'(acc0) + CW'(acc1);
  assign empty   = (count == '0);
  assign pop_eff = pop && !empty;
  assign drop    = (in0_vld && !acc0) || (in1_vld && !acc1);
  assign head    = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (acc0) mem[wr_ptr] <= in0;
    if (acc1) mem[acc0 ? wr_ptr + PW'(1) : wr_ptr] <= in1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      wr_ptr <= wr_ptr + PW'(n_push);
      if (pop_eff) rd_ptr <= rd_ptr + PW'(1);
      count  <= count + n_push - CW'(pop_eff);
    end
  end

  a_r9_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));
  a_r9_drop_only_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    (in0_vld && !acc0) |-> (count == CW'(DEPTH)));
endmodule

// File: rtl/trc_bus_if.sv
module trc_bus_if
  import trc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              empty,
  input  trc_entry_t        head,
  output logic              pop,
  output logic              req_valid,
  input  logic              req_ready,
  output logic              req_kind_a,
  output logic [1:0]        req_kind_b,
  output logic [7:0]        req_subcode,
  output logic              dat_valid,
  input  logic              dat_ready,
  output logic [DATA_W-1:0] dat_word,
  output logic [BE_W-1:0]   dat_be
);
  typedef enum logic {S_REQ, S_DATA} bus_st_t;
  bus_st_t state;

  logic req_fire, dat_fire;

  assign req_valid   = (state == S_REQ) && !empty;
  assign req_fire    = req_valid && req_ready;
  assign dat_valid   = (state == S_DATA);
  assign dat_fire    = dat_valid && dat_ready;
  assign pop         = (req_fire && !head.is_trace) || dat_fire;

  assign req_kind_a  = head.is_trace;
  assign req_kind_b  = trc_kind_b(head.is_trace);
  assign req_subcode = trc_sub_code(head.is_trace, head.code);
  assign dat_word    = head.data;
  assign dat_be      = dat_valid ? '1 : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) state <= S_REQ;
    else begin
      case (state)
        S_REQ:  if (req_fire && head.is_trace) state <= S_DATA;
        S_DATA: if (dat_fire) state <= S_REQ;
        default: state <= S_REQ;
      endcase
    end
  end

  a_r8_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_subcode) && $stable(req_kind_a)));
  a_r8_dat_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_valid && !dat_ready) |=> (dat_valid && $stable(dat_word)));
  a_r8_dat_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (req_fire && req_kind_a) |=> dat_valid);
  a_r11_no_special_data: assert property (@(posedge clk) disable iff (!rst_n)
    (req_fire && !req_kind_a) |=> !dat_valid);
  a_r4_full_be: assert property (@(posedge clk) disable iff (!rst_n)
    dat_valid |-> (dat_be == '1));
  a_r5_trace_fields: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_kind_a) |-> (req_subcode == 8'hFF && req_kind_b == 2'b00));
  a_r6_special_fields: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_kind_a) |-> (req_subcode[7:3] == 5'd0 && req_kind_b == 2'b01));
  a_r8_phase_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && dat_valid));
endmodule

// File: rtl/trace_msg_gen.sv
module trace_msg_gen
  import trc_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        trace_en,
  input  logic        br_valid,
  input  logic [31:0] br_target,
  input  logic [31:0] br_insn_addr,
  input  logic [31:0] br_next_addr,
  input  logic        br_normal,
  input  logic        sp_valid,
  input  logic [2:0]  sp_code,
  output logic        req_valid,
  input  logic        req_ready,
  output logic        req_kind_a,
  output logic [1:0]  req_kind_b,
  output logic [7:0]  req_subcode,
  output logic        dat_valid,
  input  logic        dat_ready,
  output logic [63:0] dat_word,
  output logic [7:0]  dat_be,
  output logic        overflow
);
  logic       slot0_vld, slot1_vld, fifo_empty, fifo_pop, fifo_drop;
  trc_entry_t slot0, slot1, fifo_head;

  trc_encoder u_enc (
    .trace_en, .br_valid, .br_target, .br_insn_addr, .br_next_addr, .br_normal,
    .sp_valid, .sp_code,
    .slot0_vld, .slot0, .slot1_vld, .slot1
  );

  trc_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk, .rst_n,
    .in0_vld(slot0_vld), .in0(slot0), .in1_vld(slot1_vld), .in1(slot1),
    .pop(fifo_pop), .head(fifo_head), .empty(fifo_empty), .drop(fifo_drop)
  );

  trc_bus_if u_bus (
    .clk, .rst_n,
    .empty(fifo_empty), .head(fifo_head), .pop(fifo_pop),
    .req_valid, .req_ready, .req_kind_a, .req_kind_b, .req_subcode,
    .dat_valid, .dat_ready, .dat_word, .dat_be
  );

  always_ff @(posedge clk) begin
    if (!rst_n)         overflow <= 1'b0;
    else if (fifo_drop) overflow <= 1'b1;
  end

  a_r9_overflow_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);
  a_r9_overflow_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overflow) |-> $past(br_valid || sp_valid));
endmodule

// File: tb/sim_trace_msg_gen.sv
module sim_trace_msg_gen;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        trace_en, br_valid, br_normal, sp_valid;
  logic [31:0] br_target, br_insn_addr, br_next_addr;
  logic [2:0]  sp_code;
  logic        req_valid, req_ready, req_kind_a;
  logic [1:0]  req_kind_b;
  logic [7:0]  req_subcode;
  logic        dat_valid, dat_ready;
  logic [63:0] dat_word;
  logic [7:0]  dat_be;
  logic        overflow;

  int vectors = 0;
  int fails   = 0;
  int cyc     = 0;

  always #2.5 clk = ~clk;

  trace_msg_gen u0 (.*);

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 20000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  task automatic branch_ev(input logic [31:0] t, input logic [31:0] i, input logic [31:0] n, input logic nrm);
    br_valid = 1'b1; br_target = t; br_insn_addr = i; br_next_addr = n; br_normal = nrm;
    @(negedge clk);
    br_valid = 1'b0;
  endtask

  task automatic special_ev(input logic [2:0] c);
    sp_valid = 1'b1; sp_code = c;
    @(negedge clk);
    sp_valid = 1'b0;
  endtask

  task automatic wait_req();
    for (int k = 0; k < 20 && !req_valid; k++) @(negedge clk);
  endtask

  // Accept one trace request and its data phase, checking R5/R8/R4/R2/R3.
  task automatic expect_trace(input logic [63:0] exp, input string tag);
    wait_req();
    chk(req_valid == 1'b1, {tag, " R8 req_valid"}, 64'(req_valid), 64'd1);
    chk(req_kind_a == 1'b1 && req_kind_b == 2'b00 && req_subcode == 8'hFF,
        {tag, " R5 trace fields"}, {53'd0, req_kind_a, req_kind_b, req_subcode}, {53'd0, 1'b1, 2'b00, 8'hFF});
    req_ready = 1'b1;
    @(negedge clk);
    req_ready = 1'b0;
    chk(dat_valid == 1'b1, {tag, " R8 data next cycle"}, 64'(dat_valid), 64'd1);
    chk(dat_be == 8'hFF, {tag, " R4 byte enables"}, 64'(dat_be), 64'hFF);
    chk(dat_word[63:32] == exp[63:32], {tag, " R2 target word"}, 64'(dat_word[63:32]), 64'(exp[63:32]));
    chk(dat_word[31:0] == exp[31:0], {tag, " R3 low word"}, 64'(dat_word[31:0]), 64'(exp[31:0]));
    dat_ready = 1'b1;
    @(negedge clk);
    dat_ready = 1'b0;
    chk(dat_valid == 1'b0 && dat_be == 8'h00, {tag, " R4 data phase ends"}, {55'd0, dat_valid, dat_be}, 64'd0);
  endtask

  task automatic expect_special(input logic [2:0] c, input string tag);
    wait_req();
    chk(req_valid == 1'b1 && req_kind_a == 1'b0 && req_kind_b == 2'b01 && req_subcode == {5'd0, c},
        {tag, " R6 special fields"}, {52'd0, req_valid, req_kind_a, req_kind_b, req_subcode},
        {52'd0, 1'b1, 1'b0, 2'b01, 5'd0, c});
    req_ready = 1'b1;
    @(negedge clk);
    req_ready = 1'b0;
    chk(dat_valid == 1'b0, {tag, " R11 no data phase"}, 64'(dat_valid), 64'd0);
  endtask

  task automatic t_reset();
    chk(req_valid == 0 && dat_valid == 0 && overflow == 0, "R12 reset state",
        {61'd0, req_valid, dat_valid, overflow}, 64'd0);
  endtask

  task automatic t_normal_and_abnormal();
    branch_ev(32'h1000_0040, 32'h0000_2000, 32'h0000_2002, 1'b1);
    expect_trace({32'h1000_0040, 32'h0000_2002}, "normal R3");
    branch_ev(32'hCAFE_0000, 32'h0000_3000, 32'h0000_3005, 1'b0);
    expect_trace({32'hCAFE_0000, 32'h0000_3000}, "abnormal R3");
  endtask

  task automatic t_disabled();
    trace_en = 1'b0;
    branch_ev(32'hDEAD_BEEF, 32'h1, 32'h2, 1'b1);
    repeat (3) @(negedge clk);
    chk(req_valid == 1'b0, "R1 no trace when disabled", 64'(req_valid), 64'd0);
    trace_en = 1'b1;
  endtask

  task automatic t_specials();
    special_ev(3'd5);
    expect_special(3'd5, "flush-ack");
    special_ev(3'd7);
    expect_special(3'd7, "code7");
    special_ev(3'd0);
    expect_special(3'd0, "nop");
  endtask

  task automatic t_same_cycle();
    sp_valid = 1'b1; sp_code = 3'd2;
    branch_ev(32'h5555_0000, 32'h10, 32'h14, 1'b1);
    sp_valid = 1'b0;
    expect_special(3'd2, "R7 special first");
    expect_trace({32'h5555_0000, 32'h14}, "R7 trace second");
  endtask

  task automatic t_hold();
    branch_ev(32'h7777_0000, 32'h20, 32'h24, 1'b0);
    repeat (3) @(negedge clk);
    chk(req_valid == 1'b1 && req_subcode == 8'hFF, "R8 request held",
        {55'd0, req_valid, req_subcode}, {55'd0, 1'b1, 8'hFF});
    req_ready = 1'b1;
    @(negedge clk);
    req_ready = 1'b0;
    repeat (2) @(negedge clk);
    chk(dat_valid == 1'b1 && dat_word == {32'h7777_0000, 32'h20}, "R8 data held",
        dat_word, {32'h7777_0000, 32'h20});
    dat_ready = 1'b1;
    @(negedge clk);
    dat_ready = 1'b0;
  endtask

  task automatic t_drain_after_disable();
    branch_ev(32'hA000_0001, 32'h30, 32'h34, 1'b1);
    branch_ev(32'hA000_0002, 32'h40, 32'h44, 1'b0);
    trace_en = 1'b0;
    expect_trace({32'hA000_0001, 32'h34}, "R10 first kept");
    expect_trace({32'hA000_0002, 32'h40}, "R10 second kept");
    trace_en = 1'b1;
  endtask

  task automatic t_overflow();
    for (int k = 0; k < 4; k++) branch_ev(32'hB000_0000 + k, 32'h100 + k, 32'h200 + k, 1'b1);
    chk(overflow == 1'b0, "R9 no overflow at depth", 64'(overflow), 64'd0);
    branch_ev(32'hBFFF_FFFF, 32'h1, 32'h2, 1'b1);
    chk(overflow == 1'b1, "R9 overflow on drop", 64'(overflow), 64'd1);
    for (int k = 0; k < 4; k++)
      expect_trace({32'hB000_0000 + k, 32'h200 + k}, "R9 queued order");
    repeat (2) @(negedge clk);
    chk(req_valid == 1'b0, "R9 dropped entry absent", 64'(req_valid), 64'd0);
    chk(overflow == 1'b1, "R9 overflow sticky", 64'(overflow), 64'd1);
  endtask

  initial begin
    rst_n = 1'b0; trace_en = 1'b1; br_valid = 1'b0; sp_valid = 1'b0; sp_code = '0;
    br_target = '0; br_insn_addr = '0; br_next_addr = '0; br_normal = 1'b0;
    req_ready = 1'b0; dat_ready = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_normal_and_abnormal();
    t_disabled();
    t_specials();
    t_same_cycle();
    t_hold();
    t_drain_after_disable();
    t_overflow();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule